// File: doc/BRIEF.md
# Seven-Segment Ring Sequencer

This block drives one seven-segment digit as a spinning ring. While running, it lights the six outer segments one at a time and walks them around the digit in either rotational sense. A single active-low push-button both starts and stops the animation. A stop is not immediate: the ring finishes the lap in progress and only then falls back to the resting pattern, which lights the middle bar alone.

The step period comes from a divider on the system clock. A speed switch picks one of two cycle counts, by default 200 ms and 100 ms worth of a 50 MHz clock. A direction switch picks the walking order. The order is latched at the first step of every lap, so flipping the switch mid-lap never breaks a lap apart. A 16-bit counter reports how many full laps have been completed since reset.

The controller has three states. `ST_IDLE` is resting: the middle bar is lit and the step timer is held clear. `ST_RUN` is spinning with no stop pending. `ST_DRAIN` is spinning with a stop pending. The transitions are these:
- **start**: `ST_IDLE`→`ST_RUN` on a button press.
- **stop request**: `ST_RUN`→`ST_DRAIN` on a button press.
- **lap wrap**: `ST_RUN`→`ST_RUN` when the last step of a lap ends. The position returns to the first step and the direction is sampled again.
- **lap end**: `ST_DRAIN`→`ST_IDLE` when the last step of the lap ends.

A press seen in `ST_DRAIN` changes nothing.

Top module: `seg_ring_sequencer`

## Requirements
- R1: After reset, and whenever the controller rests, `seg` equals 7'h40 (only bit 6, the middle bar g, lit) and the step timer has no effect on the output.
- R2: A high-to-low transition of `start_n`, seen after a two-flop synchronizer, moves a resting controller into spinning. The first segment shown is a (`seg` = 7'h01).
- R3: The segment encoding is bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f, bit 6 = g. With `dir_cw` = 1, a lap shows a, b, c, d, e, f in that order.
- R4: With `dir_cw` = 0, a lap shows a, f, e, d, c, b in that order.
- R5: Exactly one bit of `seg` is set in every cycle.
- R6: Each step lasts SLOW_CYCLES clock cycles when `speed_fast` = 0, and FAST_CYCLES cycles when `speed_fast` = 1.
- R7: A press while spinning does not interrupt the lap. The last segment of the lap is still shown for a full step, after which `seg` returns to 7'h40.
- R8: Further presses while a stop is pending are ignored. The lap ends once, and the controller then stays resting.
- R9: `lap_count` rises by exactly one when the last step of a lap ends, wraps modulo 2^16, and is cleared by reset.
- R10: A change of `dir_cw` during a lap does not alter the remaining steps of that lap. It takes effect from the first step of the next lap.
- R11: While resting, changes on `dir_cw` and `speed_fast` leave `seg` and `lap_count` unchanged.
- R12: Holding `start_n` low, or releasing it, produces no further press. Only each new falling edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Start/stop push-button, active low, asynchronous to clk |
| dir_cw | input | 1 | Walking order: 1 = clockwise, 0 = counter-clockwise |
| speed_fast | input | 1 | Step period select: 1 = FAST_CYCLES, 0 = SLOW_CYCLES |
| seg | output | 7 | Segment lines, bit 0 = a through bit 6 = g, active high |
| lap_count | output | 16 | Completed laps since reset |

## Verification
The properties assume that reset has been applied once and that both step periods are at least one cycle. They place no demand on the button, because the press pulse they watch comes from the synchronizer rather than straight from the pin. The stimulus holds `start_n` low for several cycles on every press and changes the switches only between clock edges. A stop press is always placed well inside a lap, after waiting on the displayed segment, so it never coincides with the end of a lap. Direction and speed are toggled freely while resting, because in that state the block must ignore them.

// File: rtl/seg_ring_pkg.sv
package seg_ring_pkg;

    // Outer ring has six positions; the digit has seven lines.
    localparam int RING_POSITIONS = 6;
    localparam int SEG_LINES      = 7;
    localparam int POS_W          = $clog2(RING_POSITIONS);

    // Resting pattern: middle bar only.
    localparam logic [SEG_LINES-1:0] SEG_REST = 7'h40;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } ring_state_e;

endpackage

// File: rtl/seg_ring_press_detect.sv
module seg_ring_press_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press
);

    // stage[0..SYNC_STAGES-1] synchronize; stage[SYNC_STAGES] remembers
    // the previous synchronized level for edge detection.
    logic [SYNC_STAGES:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= 1'b1;
        end else begin
            stage_q[0] <= btn_n;
        end
    end

    for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[i] <= 1'b1;
            end else begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    // One-cycle pulse on a synchronized high-to-low transition.
    assign press = stage_q[SYNC_STAGES] & ~stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/seg_ring_step_timer.sv
module seg_ring_step_timer #(
    parameter int SLOW_CYCLES = 10_000_000,
    parameter int FAST_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fast,
    output logic tick
);

    localparam int MAX_CYCLES = (SLOW_CYCLES > FAST_CYCLES) ? SLOW_CYCLES : FAST_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CYCLES - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = fast ? FAST_LAST : SLOW_LAST;
    // ">=" keeps the period bounded if the speed switch drops the limit mid-step.
    assign tick     = enable && (cnt_q >= last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/seg_ring_map.sv
module seg_ring_map
    import seg_ring_pkg::*;
(
    input  logic [POS_W-1:0]          pos,
    input  logic                      cw,
    output logic [RING_POSITIONS-1:0] ring
);

    // Outer segment i is lit at position i going clockwise, and at
    // position (N - i) mod N going counter-clockwise; both start at a.
    for (genvar i = 0; i < RING_POSITIONS; i++) begin : g_seg
        localparam logic [POS_W-1:0] CW_POS  = POS_W'(i);
        localparam logic [POS_W-1:0] CCW_POS = POS_W'((RING_POSITIONS - i) % RING_POSITIONS);
        assign ring[i] = cw ? (pos == CW_POS) : (pos == CCW_POS);
    end

endmodule

// File: rtl/seg_ring_sequencer.sv
module seg_ring_sequencer
    import seg_ring_pkg::*;
#(
    parameter int SLOW_CYCLES = 10_000_000,
    parameter int FAST_CYCLES = 5_000_000,
    parameter int LAP_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic             dir_cw,
    input  logic             speed_fast,
    output logic [6:0]       seg,
    output logic [LAP_W-1:0] lap_count
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(RING_POSITIONS - 1);

    ring_state_e             state_q, state_d;
    logic [POS_W-1:0]        pos_q;
    logic                    lap_cw_q;
    logic [LAP_W-1:0]        laps_q;
    logic                    press_pulse;
    logic                    step_tick;
    logic                    lap_done;
    logic                    is_idle;
    logic [RING_POSITIONS-1:0] ring_lines;

    seg_ring_press_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_press (
        .clk  (clk),
        .rst_n(rst_n),
        .btn_n(start_n),
        .press(press_pulse)
    );

    seg_ring_step_timer #(
        .SLOW_CYCLES(SLOW_CYCLES),
        .FAST_CYCLES(FAST_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(!is_idle),
        .fast  (speed_fast),
        .tick  (step_tick)
    );

    seg_ring_map u_map (
        .pos (pos_q),
        .cw  (lap_cw_q),
        .ring(ring_lines)
    );

    assign is_idle  = (state_q == ST_IDLE);
    assign lap_done = step_tick && (pos_q == LAST_POS);

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (press_pulse) state_d = ST_RUN;
            ST_RUN:   if (press_pulse) state_d = ST_DRAIN;
            ST_DRAIN: if (lap_done)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register together with the position, lap direction and lap count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pos_q    <= '0;
            lap_cw_q <= 1'b1;
            laps_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    pos_q    <= '0;
                    lap_cw_q <= dir_cw;
                end
                ST_RUN, ST_DRAIN: begin
                    if (lap_done) begin
                        pos_q    <= '0;
                        lap_cw_q <= dir_cw;
                        laps_q   <= laps_q + LAP_W'(1);
                    end else if (step_tick) begin
                        pos_q <= pos_q + POS_W'(1);
                    end
                end
                default: begin
                    pos_q <= '0;
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_RUN, ST_DRAIN: seg = {1'b0, ring_lines};
            default:          seg = SEG_REST;
        endcase
    end

    assign lap_count = laps_q;

endmodule

// File: rtl/seg_ring_checker.sv
module seg_ring_checker #(
    parameter int LAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       seg,
    input logic [LAP_W-1:0] laps,
    input logic             press,
    input logic             idle
);

    assert_one_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg) == 1);

    assert_rest_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> seg == 7'h40);

    assert_start_at_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && press) |=> seg == 7'h01);

    assert_rest_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !press) |=> (idle && $stable(laps)));

    assert_lap_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (laps != $past(laps)) |-> (laps == $past(laps) + LAP_W'(1)));

    assert_lap_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (laps != $past(laps)) |-> ($past(seg) == 7'h20 || $past(seg) == 7'h02));

    assert_ring_neighbour_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle) && seg != $past(seg)) |->
        (seg[6] == 1'b0 &&
         (seg[5:0] == {$past(seg[4:0]), $past(seg[5])} ||
          seg[5:0] == {$past(seg[0]), $past(seg[5:1])})));

endmodule

bind seg_ring_sequencer seg_ring_checker #(
    .LAP_W(LAP_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .seg  (seg),
    .laps (lap_count),
    .press(press_pulse),
    .idle (is_idle)
);

// File: tb/seg_ring_sequencer_tb.sv
module seg_ring_sequencer_tb;

    localparam int SLOW = 8;
    localparam int FAST = 4;
    localparam logic [6:0] SA = 7'h01, SB = 7'h02, SC = 7'h04, SD = 7'h08,
                           SE = 7'h10, SF = 7'h20, SG = 7'h40;

    typedef struct {
        logic [6:0] seg;
        int         hold;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_n = 1'b1;
    logic        dir_cw = 1'b1;
    logic        speed_fast = 1'b0;
    logic [6:0]  seg;
    logic [15:0] lap_count;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    seg_ring_sequencer #(
        .SLOW_CYCLES(SLOW),
        .FAST_CYCLES(FAST)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n   (start_n),
        .dir_cw    (dir_cw),
        .speed_fast(speed_fast),
        .seg       (seg),
        .lap_count (lap_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [6:0] s, input int hold, input string req);
        exp_t e;
        e.seg = s; e.hold = hold; e.req = req;
        exp_q.push_back(e);
    endtask

    // One lap of expectations; first_hold is the hold of the segment before it.
    task automatic push_lap(input bit cw, input int first_hold, input int p, input string req);
        logic [6:0] cw_ord [6]  = '{SA, SB, SC, SD, SE, SF};
        logic [6:0] ccw_ord [6] = '{SA, SF, SE, SD, SC, SB};
        for (int i = 0; i < 6; i++) begin
            push(cw ? cw_ord[i] : ccw_ord[i], (i == 0) ? first_hold : p, req);
        end
    endtask

    task automatic press(input int low_cycles);
        @(negedge clk) start_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        start_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_seg(input logic [6:0] s);
        int i;
        for (i = 0; i < 2000 && seg != s; i++) @(negedge clk);
        check(seg == s, "R3", "segment never shown", seg, s);
    endtask

    task automatic wait_laps(input int n);
        int i;
        for (i = 0; i < 2000 && lap_count != 16'(n); i++) @(negedge clk);
        check(lap_count == 16'(n), "R9", "lap count not reached", lap_count, n);
    endtask

    task automatic wait_drained();
        int i;
        for (i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R7", "expected segments left", exp_q.size(), 0);
    endtask

    // Monitor: pops one expected item for every change of seg.
    initial begin : monitor
        logic [6:0] prev;
        int held;
        exp_t e;
        prev = SG;
        held = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            held++;
            if (seg != prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected segment change", seg, prev);
                end else begin
                    e = exp_q.pop_front();
                    check(seg == e.seg, e.req, "segment order", seg, e.seg);
                    if (e.hold != 0) check(held == e.hold, "R6", "step length", held, e.hold);
                end
                prev = seg;
                held = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1: reset state
        check(seg == SG, "R1", "reset segment", seg, SG);
        check(lap_count == 0, "R9", "reset lap count", lap_count, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(seg == SG, "R1", "idle segment", seg, SG);

        // R2 R3 R6 R7: clockwise slow, two laps, stop during the second
        dir_cw = 1'b1; speed_fast = 1'b0;
        push_lap(1'b1, 0, SLOW, "R3");
        push_lap(1'b1, SLOW, SLOW, "R3");
        push(SG, SLOW, "R7");
        press(4);
        wait_laps(1);
        wait_seg(SC);
        press(4);
        wait_drained();
        check(lap_count == 2, "R9", "laps after cw run", lap_count, 2);

        // R4 R6: counter-clockwise fast, one lap
        dir_cw = 1'b0; speed_fast = 1'b1;
        push_lap(1'b0, 0, FAST, "R4");
        push(SG, FAST, "R7");
        press(4);
        wait_seg(SF);
        press(4);
        wait_drained();
        check(lap_count == 3, "R9", "laps after ccw run", lap_count, 3);

        // R10: direction flip mid-lap applies from the next lap
        dir_cw = 1'b1; speed_fast = 1'b0;
        push_lap(1'b1, 0, SLOW, "R10");
        push_lap(1'b0, SLOW, SLOW, "R10");
        push(SG, SLOW, "R7");
        press(4);
        wait_seg(SC);
        dir_cw = 1'b0;
        wait_laps(4);
        wait_seg(SE);
        press(4);
        wait_drained();
        check(lap_count == 5, "R9", "laps after flip run", lap_count, 5);

        // R8: second press while a stop is pending
        dir_cw = 1'b1; speed_fast = 1'b1;
        push_lap(1'b1, 0, FAST, "R8");
        push(SG, FAST, "R8");
        press(4);
        wait_seg(SB);
        press(4);
        wait_seg(SD);
        press(4);
        wait_drained();
        repeat (40) @(negedge clk);
        check(seg == SG, "R8", "stays resting", seg, SG);
        check(lap_count == 6, "R8", "single lap counted", lap_count, 6);

        // R11: switches toggled while resting
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            dir_cw = ~dir_cw;
            speed_fast = (i % 3) == 0;
            repeat (5) @(negedge clk);
        end
        check(seg == SG, "R11", "resting segment", seg, SG);
        check(lap_count == 6, "R11", "resting lap count", lap_count, 6);
        check(exp_q.size() == 0, "R11", "no change seen", exp_q.size(), 0);

        // R12: long hold of the button starts once only
        dir_cw = 1'b1; speed_fast = 1'b1;
        push_lap(1'b1, 0, FAST, "R12");
        push_lap(1'b1, FAST, FAST, "R12");
        push(SG, FAST, "R12");
        press(20);
        wait_laps(7);
        wait_seg(SC);
        press(4);
        wait_drained();
        check(lap_count == 8, "R12", "laps after long hold", lap_count, 8);

        // R9: reset clears the lap counter
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(lap_count == 0, "R9", "cleared by reset", lap_count, 0);
        check(seg == SG, "R1", "reset segment again", seg, SG);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule